// File: doc/BRIEF.md
# Bit-Programmable Nonvolatile Store Controller

This block sequences operations on a 128-bit nonvolatile array, held here as a register array of eight 16-bit words. A host asks for one of four operations: clear the whole array, start programming one bit, finish programming that bit, or read one bit. Programming can only move a bit from 0 to 1; the only way back to 0 is a whole-array clear. Programming is a two-step affair: a begin request opens a long busy interval (about 50 ms, given in clock cycles), after which the block waits for a matching end request. The end request is followed by a short settling interval.

Clearing and programming need both the write-enable level and chip select high. Reading needs only chip select, and the bit comes back after a fixed latency. Any request that arrives while the block is busy, or while it waits for an end request, is refused and leaves the array as it was. A separate read port gives a neighbouring refresh engine one word at a time. It returns the 12-bit payload of that word and a flag that says whether the reserved bits are clean. An end request whose address does not match the pending begin is flagged, but the bit from the begin request is still set. A saturating count of clear operations raises a wear flag once it goes past a limit.

Top module: `nvbit_ctrl`

## Requirements
- R1: After reset every array bit reads 0 and busy_o, wait_end_o, rd_valid_o, addr_err_o and wear_o are low.
- R2: Opcode 2'b00 (clear), accepted only in idle with cs_i and we_i high, holds busy_o for BUSY_CYC cycles and then leaves all 128 bits at 0.
- R3: Opcode 2'b01 (begin) at address a, then opcode 2'b10 (end), sets bit a to 1 and leaves every other bit unchanged. A bit already at 1 stays at 1.
- R4: While busy_o is high, cmd_accept_o stays low and the array does not change.
- R5: Clear, begin and end are refused when we_i or cs_i is low. Read is refused when cs_i is low, but it does not need we_i.
- R6: After the busy interval of a begin request, wait_end_o goes high. Accepting the end request then holds busy_o for exactly SETTLE_CYC cycles.
- R7: Opcode 2'b11 (read) holds busy_o for READ_CYC cycles. rd_valid_o then pulses for one cycle, and rd_data_o carries the addressed bit.
- R8: If the end address differs from the pending begin address, addr_err_o pulses for one cycle after the accept. The begin address bit is still set.
- R9: The refresh port returns bits 16w..16w+11 of word w = ref_word_i on ref_data_o, with the lower address at bit 0. ref_rsvd_ok_o is low if any of bits 16w+12..16w+15 is set, or if w = 5 and any bit of that word is set.
- R10: wear_o goes high once more than WEAR_LIMIT clear requests have been accepted, and stays high.
- R11: While wait_end_o is high, only an end request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select level |
| we_i | input | 1 | Write-enable level for clear and program |
| cmd_valid_i | input | 1 | Request present |
| cmd_op_i | input | 2 | 00 clear, 01 begin, 10 end, 11 read |
| cmd_addr_i | input | 7 | Bit address 0..127 |
| cmd_accept_o | output | 1 | Request taken on this edge |
| busy_o | output | 1 | Busy, settling or read latency in progress |
| wait_end_o | output | 1 | Waiting for the end request |
| addr_err_o | output | 1 | End address mismatch pulse |
| rd_valid_o | output | 1 | Read result pulse |
| rd_data_o | output | 1 | Read result bit |
| ref_word_i | input | 3 | Word index for refresh |
| ref_data_o | output | 12 | Payload of the selected word |
| ref_rsvd_ok_o | output | 1 | Reserved bits clean |
| wear_o | output | 1 | Clear count past the limit |

## Verification
The bench goes after the following corner cases, each paired with the failure it would expose:
- **Busy-window requests.** It sends clear, read and begin requests inside the busy window and during the wait for the end request. A design that let any of them through would wipe or corrupt bits that the refresh port then shows.
- **Mismatched end address.** It sends an end request at a different address. A design that set the end address instead of the begin address, or that failed to pulse the error, shows up as a wrong bit on readback.
- **Interval lengths.** It counts the busy interval for clear, settling and read to the cycle. This catches an off-by-one timer.
- **Reserved bits.** It sets reserved bits, including in the all-zero word, and checks that the clean flag drops.
- **Wear threshold.** It drives the clear count exactly to the limit and then one past it. This catches a threshold at the wrong side of the limit.

// File: rtl/nvbit_pkg.sv
package nvbit_pkg;
  typedef enum logic [1:0] {
    OP_ERASE = 2'b00,
    OP_BEGIN = 2'b01,
    OP_END   = 2'b10,
    OP_READ  = 2'b11
  } nv_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ERASE, S_WRITE, S_WAIT_END, S_SETTLE, S_READ
  } nv_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/nvbit_array.sv
module nvbit_array #(
  parameter int N_WORDS = 8,
  parameter int WORD_W  = 16,
  localparam int AW  = $clog2(N_WORDS * WORD_W),
  localparam int BW  = $clog2(WORD_W),
  localparam int WAW = $clog2(N_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              set_i,
  input  logic [AW-1:0]     set_addr_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic              rd_bit_o,
  input  logic [WAW-1:0]    ref_word_i,
  output logic [WORD_W-1:0] ref_word_o
);
  logic [WORD_W-1:0] mem [N_WORDS];

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem[w] <= '0;
      else if (clr_i)
        mem[w] <= '0;
      else if (set_i && set_addr_i[AW-1:BW] == WAW'(w))
        mem[w][set_addr_i[BW-1:0]] <= 1'b1;  // program only raises bits
    end
  end

  assign rd_bit_o   = mem[rd_addr_i[AW-1:BW]][rd_addr_i[BW-1:0]];
  assign ref_word_o = mem[ref_word_i];
endmodule

// File: rtl/nvbit_seq.sv
module nvbit_seq
  import nvbit_pkg::*;
#(
  parameter int AW         = 7,
  parameter int BUSY_CYC   = 6_250_000,
  parameter int SETTLE_CYC = 125_000,
  parameter int READ_CYC   = 25_000,
  localparam int CNT_W = $clog2(max3(BUSY_CYC, SETTLE_CYC, READ_CYC) + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic          rd_bit_i,
  output logic          accept_o,
  output logic          erase_go_o,
  output logic          busy_o,
  output logic          wait_end_o,
  output logic          set_o,
  output logic [AW-1:0] set_addr_o,
  output logic          clr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          rd_valid_o,
  output logic          rd_data_o,
  output logic          addr_err_o
);
  localparam logic [CNT_W-1:0] BUSY_LD   = CNT_W'(BUSY_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] READ_LD   = CNT_W'(READ_CYC - 1);

  nv_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    pend_q, rd_addr_q;
  nv_op_e           op;
  logic             go, done;
  logic             acc_erase, acc_begin, acc_read, acc_end;

  assign op        = nv_op_e'(cmd_op_i);
  assign go        = cmd_valid_i && cs_i;
  assign done      = (cnt == '0);
  assign acc_erase = (st == S_IDLE) && go && we_i && (op == OP_ERASE);
  assign acc_begin = (st == S_IDLE) && go && we_i && (op == OP_BEGIN);
  assign acc_read  = (st == S_IDLE) && go && (op == OP_READ);
  assign acc_end   = (st == S_WAIT_END) && go && we_i && (op == OP_END);

  assign accept_o   = acc_erase || acc_begin || acc_read || acc_end;
  assign erase_go_o = acc_erase;
  assign busy_o     = (st == S_ERASE) || (st == S_WRITE) || (st == S_SETTLE) || (st == S_READ);
  assign wait_end_o = (st == S_WAIT_END);
  assign set_o      = acc_end;
  assign set_addr_o = pend_q;            // commit begin address even on mismatch
  assign clr_o      = (st == S_ERASE) && done;
  assign rd_addr_o  = rd_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= S_IDLE;
      cnt        <= '0;
      pend_q     <= '0;
      rd_addr_q  <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= 1'b0;
      addr_err_o <= 1'b0;
    end else begin
      rd_valid_o <= 1'b0;
      addr_err_o <= 1'b0;
      case (st)
        S_IDLE: begin
          if (acc_erase) begin
            st  <= S_ERASE;
            cnt <= BUSY_LD;
          end else if (acc_begin) begin
            st     <= S_WRITE;
            cnt    <= BUSY_LD;
            pend_q <= cmd_addr_i;
          end else if (acc_read) begin
            st        <= S_READ;
            cnt       <= READ_LD;
            rd_addr_q <= cmd_addr_i;
          end
        end
        S_ERASE:  if (done) st <= S_IDLE;     else cnt <= cnt - CNT_W'(1);
        S_WRITE:  if (done) st <= S_WAIT_END; else cnt <= cnt - CNT_W'(1);
        S_WAIT_END: begin
          if (acc_end) begin
            st         <= S_SETTLE;
            cnt        <= SETTLE_LD;
            addr_err_o <= (cmd_addr_i != pend_q);
          end
        end
        S_SETTLE: if (done) st <= S_IDLE; else cnt <= cnt - CNT_W'(1);
        S_READ: begin
          if (done) begin
            st         <= S_IDLE;
            rd_valid_o <= 1'b1;
            rd_data_o  <= rd_bit_i;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvbit_wear.sv
module nvbit_wear #(
  parameter int LIMIT = 100,
  localparam int CW = $clog2(LIMIT + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  output logic wear_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt <= '0;
    else if (inc_i && cnt != '1) cnt <= cnt + CW'(1);
  end

  assign wear_o = (cnt > CW'(LIMIT));
endmodule

// File: rtl/nvbit_ctrl.sv
module nvbit_ctrl #(
  parameter int N_WORDS    = 8,
  parameter int WORD_W     = 16,
  parameter int RSVD_W     = 4,
  parameter int ZERO_WORD  = 5,
  parameter int BUSY_CYC   = 6_250_000,
  parameter int SETTLE_CYC = 125_000,
  parameter int READ_CYC   = 25_000,
  parameter int WEAR_LIMIT = 100,
  localparam int AW    = $clog2(N_WORDS * WORD_W),
  localparam int WAW   = $clog2(N_WORDS),
  localparam int PAY_W = WORD_W - RSVD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             we_i,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [AW-1:0]    cmd_addr_i,
  output logic             cmd_accept_o,
  output logic             busy_o,
  output logic             wait_end_o,
  output logic             addr_err_o,
  output logic             rd_valid_o,
  output logic             rd_data_o,
  input  logic [WAW-1:0]   ref_word_i,
  output logic [PAY_W-1:0] ref_data_o,
  output logic             ref_rsvd_ok_o,
  output logic             wear_o
);
  logic              set, clr, erase_go, rd_bit;
  logic [AW-1:0]     set_addr, rd_addr;
  logic [WORD_W-1:0] ref_word;

  nvbit_seq #(
    .AW(AW), .BUSY_CYC(BUSY_CYC), .SETTLE_CYC(SETTLE_CYC), .READ_CYC(READ_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .cs_i, .we_i, .cmd_valid_i, .cmd_op_i, .cmd_addr_i,
    .rd_bit_i   (rd_bit),
    .accept_o   (cmd_accept_o),
    .erase_go_o (erase_go),
    .busy_o, .wait_end_o,
    .set_o      (set),
    .set_addr_o (set_addr),
    .clr_o      (clr),
    .rd_addr_o  (rd_addr),
    .rd_valid_o, .rd_data_o, .addr_err_o
  );

  nvbit_array #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_arr (
    .clk_i, .rst_ni,
    .clr_i      (clr),
    .set_i      (set),
    .set_addr_i (set_addr),
    .rd_addr_i  (rd_addr),
    .rd_bit_o   (rd_bit),
    .ref_word_i,
    .ref_word_o (ref_word)
  );

  nvbit_wear #(.LIMIT(WEAR_LIMIT)) u_wear (
    .clk_i, .rst_ni, .inc_i(erase_go), .wear_o
  );

  assign ref_data_o    = ref_word[PAY_W-1:0];
  assign ref_rsvd_ok_o = (ref_word[WORD_W-1:PAY_W] == '0) &&
                         !((ref_word_i == WAW'(ZERO_WORD)) && (ref_word != '0));
endmodule

// File: rtl/nvbit_ctrl_chk.sv
module nvbit_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_i,
  input logic       we_i,
  input logic       cmd_valid_i,
  input logic [1:0] cmd_op_i,
  input logic       cmd_accept_o,
  input logic       busy_o,
  input logic       wait_end_o,
  input logic       addr_err_o,
  input logic       rd_valid_o,
  input logic       wear_o
);
  p_no_accept_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cmd_accept_o);

  p_write_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_accept_o && cmd_op_i != 2'b11) |-> (cs_i && we_i));

  p_read_cs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_accept_o |-> (cs_i && cmd_valid_i));

  p_erase_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_accept_o && cmd_op_i == 2'b00) |=> busy_o);

  p_settle_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_accept_o && cmd_op_i == 2'b10) |=> (busy_o && !wait_end_o));

  p_end_only_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_end_o && cmd_accept_o) |-> (cmd_op_i == 2'b10));

  p_err_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> $past(cmd_accept_o && cmd_op_i == 2'b10 && wait_end_o));

  p_rd_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  p_wear_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wear_o |=> wear_o);
endmodule

bind nvbit_ctrl nvbit_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i),
  .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_accept_o(cmd_accept_o),
  .busy_o(busy_o), .wait_end_o(wait_end_o), .addr_err_o(addr_err_o),
  .rd_valid_o(rd_valid_o), .wear_o(wear_o)
);

// File: tb/sim_nvbit_ctrl.sv
module sim_nvbit_ctrl;
  localparam int BUSY = 20, SETL = 5, RDC = 4, WL = 100;
  localparam logic [1:0] ER = 2'b00, BG = 2'b01, EN = 2'b10, RD = 2'b11;

  // {begin addr, end addr, expected mismatch}
  localparam logic [14:0] VEC [8] = '{
    {7'h03, 7'h03, 1'b0}, {7'h10, 7'h10, 1'b0}, {7'h13, 7'h13, 1'b0},
    {7'h7F, 7'h7F, 1'b0}, {7'h20, 7'h21, 1'b1}, {7'h00, 7'h00, 1'b0},
    {7'h03, 7'h03, 1'b0}, {7'h45, 7'h2A, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b1, we = 1'b1, cval = 1'b0;
  logic [1:0] cop = 2'b00;
  logic [6:0] caddr = '0;
  logic [2:0] rw = '0;
  logic cacc, busy, wend, aerr, rval, rdat, rok, wear;
  logic [11:0] rdata;

  logic [127:0] mdl = '0;
  int n_chk = 0, n_err = 0, n_erase = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nvbit_ctrl #(.BUSY_CYC(BUSY), .SETTLE_CYC(SETL), .READ_CYC(RDC), .WEAR_LIMIT(WL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .cmd_valid_i(cval),
    .cmd_op_i(cop), .cmd_addr_i(caddr), .cmd_accept_o(cacc), .busy_o(busy),
    .wait_end_o(wend), .addr_err_o(aerr), .rd_valid_o(rval), .rd_data_o(rdat),
    .ref_word_i(rw), .ref_data_o(rdata), .ref_rsvd_ok_o(rok), .wear_o(wear)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [6:0] a, output bit acc, output bit err);
    @(negedge clk);
    cval = 1'b1; cop = op; caddr = a;
    #1 acc = cacc;
    @(posedge clk);
    @(negedge clk);
    cval = 1'b0;
    err = aerr;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic check_words(input string req);
    for (int w = 0; w < 8; w++) begin
      logic [15:0] wd;
      bit ok_exp;
      wd = mdl[w*16 +: 16];
      ok_exp = (wd[15:12] == 4'h0) && !(w == 5 && wd != 16'h0);
      rw = 3'(w);
      #1;
      chk(rdata == wd[11:0], req, int'(rdata), int'(wd[11:0]));
      chk(rok == ok_exp, req, int'(rok), int'(ok_exp));
    end
  endtask

  task automatic wr_pair(input logic [6:0] b, input logic [6:0] e, output bit err, output int nset);
    bit acc;
    cmd(BG, b, acc, err);
    chk(acc, "R3 begin accept", int'(acc), 1);
    while (!wend) @(negedge clk);
    cmd(EN, e, acc, err);
    chk(acc, "R6 end accept", int'(acc), 1);
    count_busy(nset);
    if (acc) mdl[b] = 1'b1;
  endtask

  task automatic rd_bit(input logic [6:0] a, output bit v, output bit vld, output int n);
    bit acc, err;
    cmd(RD, a, acc, err);
    chk(acc, "R7 read accept", int'(acc), 1);
    count_busy(n);
    vld = rval; v = rdat;
  endtask

  task automatic do_erase(output int n);
    bit acc, err;
    cmd(ER, 7'h00, acc, err);
    chk(acc, "R2 clear accept", int'(acc), 1);
    if (acc) n_erase++;
    count_busy(n);
    mdl = '0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit acc, err, v, vld;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !wend && !rval && !aerr && !wear, "R1 flags", int'({busy, wend, rval, aerr, wear}), 0);
    check_words("R1 array zero");

    // table walk: R3 R8 R6 R7 R9
    foreach (VEC[i]) begin
      logic [6:0] b, e;
      b = VEC[i][14:8]; e = VEC[i][7:1];
      wr_pair(b, e, err, n);
      chk(err == VEC[i][0], "R8 mismatch flag", int'(err), int'(VEC[i][0]));
      chk(n == SETL, "R6 settle cycles", n, SETL);
      rd_bit(b, v, vld, n);
      chk(vld && v, "R3 bit set", int'({vld, v}), 3);
      chk(n == RDC, "R7 read latency", n, RDC);
      if (e != b) begin
        rd_bit(e, v, vld, n);
        chk(vld && v == mdl[e], "R8 end addr untouched", int'(v), int'(mdl[e]));
      end
      check_words("R9 refresh word");
    end
    // R7 rd_valid is a single pulse
    @(negedge clk);
    chk(!rval, "R7 pulse width", int'(rval), 0);

    // R4 / R11: requests during busy and during wait for end
    cmd(BG, 7'h30, acc, err);
    chk(acc, "R4 begin", int'(acc), 1);
    cmd(ER, 7'h00, acc, err);
    chk(!acc, "R4 clear refused while busy", int'(acc), 0);
    cmd(RD, 7'h03, acc, err);
    chk(!acc, "R4 read refused while busy", int'(acc), 0);
    while (!wend) @(negedge clk);
    cmd(RD, 7'h03, acc, err);
    chk(!acc, "R11 read refused in wait", int'(acc), 0);
    cmd(ER, 7'h00, acc, err);
    chk(!acc, "R11 clear refused in wait", int'(acc), 0);
    cmd(BG, 7'h31, acc, err);
    chk(!acc && wend, "R11 begin refused in wait", int'(acc), 0);
    cmd(EN, 7'h30, acc, err);
    chk(acc, "R6 end after refusals", int'(acc), 1);
    mdl[7'h30] = 1'b1;
    count_busy(n);
    check_words("R4 array intact");

    // R5 gating
    we = 1'b0;
    cmd(BG, 7'h05, acc, err);
    chk(!acc && !busy && !wend, "R5 begin without we", int'(acc), 0);
    cmd(ER, 7'h00, acc, err);
    chk(!acc && !busy, "R5 clear without we", int'(acc), 0);
    check_words("R5 array intact");
    rd_bit(7'h10, v, vld, n);
    chk(vld && v, "R5 read without we", int'(v), 1);
    we = 1'b1; cs = 1'b0;
    cmd(RD, 7'h10, acc, err);
    chk(!acc && !busy, "R5 read without cs", int'(acc), 0);
    cmd(ER, 7'h00, acc, err);
    chk(!acc, "R5 clear without cs", int'(acc), 0);
    cs = 1'b1;
    rd_bit(7'h05, v, vld, n);
    chk(vld && !v, "R5 bit not set", int'(v), 0);

    // R9 reserved bits
    wr_pair(7'h1C, 7'h1C, err, n);
    rw = 3'd1; #1;
    chk(!rok, "R9 reserved nibble", int'(rok), 0);
    wr_pair(7'h52, 7'h52, err, n);
    rw = 3'd5; #1;
    chk(!rok && rdata == 12'h004, "R9 zero word", int'({rok, rdata}), 4);
    check_words("R9 refresh after reserved");

    // R2 clear
    do_erase(n);
    chk(n == BUSY, "R2 clear busy cycles", n, BUSY);
    check_words("R2 array cleared");
    wr_pair(7'h40, 7'h40, err, n);
    chk(mdl[7'h40], "R3 after clear", 1, 1);
    check_words("R3 single bit after clear");

    // R10 wear
    while (n_erase < WL) do_erase(n);
    @(negedge clk);
    chk(!wear, "R10 wear at limit", int'(wear), 0);
    do_erase(n);
    chk(wear, "R10 wear past limit", int'(wear), 1);
    do_erase(n);
    chk(wear, "R10 wear holds", int'(wear), 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule